// File: doc/BRIEF.md
# Byte-Serial Instruction Decoder with Decoded-Record Queue

This stage sits between a code prefetch buffer and an execution stage. It accepts one code byte per clock from upstream, assembles the bytes into instruction records and keeps completed records in a three-slot queue. The execution side drains the queue through a valid/ready port. Each record holds the opcode byte, up to three trailing bytes and the instruction length. The length comes from a two-bit field in the opcode byte.

Upstream traffic follows a low-water rule rather than a free-space rule. Once the queue has filled, the stage stops requesting bytes. It resumes only after the execution side has taken two records, so that a single record remains. From that point it keeps requesting until the queue is full again. A flush input drops every stored record and any half-built record in one cycle.

Top module: `decq_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `outValid` is 0 and `byteReq` is 1.
- R2: Bits [1:0] of the opcode byte hold a length code L, and the instruction is L+1 bytes long. `outLen` reads L+1. `outOpcode` is the opcode byte. Trailing byte k (k = 1..3) appears in `outArgs[8k-1:8k-8]`, and argument bytes beyond the length read as zero.
- R3: A byte is taken at a rising edge where `byteReq` and `byteValid` are both 1, at most one byte per edge. The completed record appears on `outValid` in the cycle after its last byte was taken.
- R4: The queue holds at most three records and delivers them in the order they were completed.
- R5: After the third record is stored, `byteReq` is 0 from the next cycle on. It stays 0 while two records remain. It returns to 1 in the cycle after the occupancy falls to one record.
- R6: Once requests have resumed, `byteReq` stays 1 as the occupancy climbs from one to two records, and drops only when the queue is full.
- R7: When `byteValid` is 0 while `byteReq` is 1, the decoder keeps its partial record, and later bytes continue that same record.
- R8: While `outValid` is 1 and `outReady` is 0, the head record is held unchanged on the output. A record is removed at an edge where both are 1.
- R9: Asserting `flush` for one cycle empties the queue and discards any partial record. A byte offered in that cycle is not taken. In the next cycle `outValid` is 0 and `byteReq` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Drop all stored and partial records |
| byteValid | input | 1 | Upstream offers a code byte |
| byteData | input | 8 | Code byte from the prefetch buffer |
| byteReq | output | 1 | Stage wants bytes; a byte is taken when this and byteValid are high |
| outValid | output | 1 | Head record present |
| outReady | input | 1 | Execution side takes the head record |
| outOpcode | output | 8 | Opcode byte of the head record |
| outArgs | output | 24 | Trailing bytes, first trailing byte in bits [7:0] |
| outLen | output | 3 | Instruction length in bytes, 1 to 4 |

## Verification
If the byte counter inside a record goes wrong, the effect shows up at the ports one cycle after the faulty byte. A trailing byte is then promoted to opcode, or an opcode lands in the argument field. Either way the next popped record carries the wrong opcode, length or argument pattern. A fault in the occupancy count or the request flag shows on `byteReq` within a cycle of the queue filling or draining to one record. Stale state that survives a flush shows up as a record on `outValid` in the cycle after the flush, or as a fresh opcode that has been absorbed as an argument byte.

// File: rtl/decq_pkg.sv
package decq_pkg;
  localparam int BYTE_W = 8;
  localparam int ARG_BYTES = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic       clear;   // flush: drop partial and stored records
    logic       take;    // a code byte is accepted this cycle
    logic       takeOp;  // the accepted byte is an opcode
    logic [1:0] argIdx;  // slot for an accepted trailing byte
    logic       push;    // record completes this cycle
    logic       pop;     // head record leaves this cycle
  } decq_strobe_t;

  typedef struct packed {
    logic [BYTE_W-1:0]           opcode;
    logic [ARG_BYTES*BYTE_W-1:0] args;
    logic [1:0]                  lenCode;
  } decq_rec_t;
endpackage

// File: rtl/decq_ctrl.sv
module decq_ctrl
  import decq_pkg::*;
#(
  parameter int DEPTH = 3,
  parameter int LOW_WATER = 1,
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             byteValid,
  input  logic [1:0]       byteLenCode,
  input  logic             outReady,
  output logic             byteReq,
  output logic             outValid,
  output logic [CNT_W-1:0] occ,
  output logic [1:0]       byteIdx,
  output decq_strobe_t     strobe
);
  logic [CNT_W-1:0] count, countNext;
  logic             refill, refillNext;
  logic [1:0]       idx, lenCodeQ, curLen;
  logic             take, last, pop;

  always_comb begin
    take   = refill && byteValid && !flush;
    curLen = (idx == 2'd0) ? byteLenCode : lenCodeQ;
    last   = take && (idx == curLen);
    pop    = (count != '0) && outReady && !flush;

    if (flush) countNext = '0;
    else       countNext = count + CNT_W'(last) - CNT_W'(pop);

    if (flush)                                refillNext = 1'b1;
    else if (countNext == CNT_W'(DEPTH))      refillNext = 1'b0;
    else if (countNext <= CNT_W'(LOW_WATER))  refillNext = 1'b1;
    else                                      refillNext = refill;

    strobe.clear  = flush;
    strobe.take   = take;
    strobe.takeOp = take && (idx == 2'd0);
    strobe.argIdx = idx - 2'd1;
    strobe.push   = last;
    strobe.pop    = pop;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count    <= '0;
      refill   <= 1'b1;
      idx      <= 2'd0;
      lenCodeQ <= 2'd0;
    end else begin
      count  <= countNext;
      refill <= refillNext;
      if (flush) begin
        idx <= 2'd0;
      end else if (take) begin
        idx <= last ? 2'd0 : idx + 2'd1;
        if (idx == 2'd0) lenCodeQ <= byteLenCode;
      end
    end
  end

  assign byteReq  = refill;
  assign outValid = (count != '0);
  assign occ      = count;
  assign byteIdx  = idx;
endmodule

// File: rtl/decq_datapath.sv
module decq_datapath
  import decq_pkg::*;
#(
  parameter int DEPTH = 3,
  parameter int PTR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  decq_strobe_t      strobe,
  input  logic [BYTE_W-1:0] byteData,
  output decq_rec_t         headRec
);
  decq_rec_t        partial, asmRec;
  decq_rec_t        slots [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  // record as it stands after this cycle's byte, so a record can be
  // stored in the same edge its last byte arrives
  always_comb begin
    asmRec = partial;
    if (strobe.takeOp) begin
      asmRec.opcode  = byteData;
      asmRec.lenCode = byteData[1:0];
      asmRec.args    = '0;
    end else if (strobe.take) begin
      asmRec.args[strobe.argIdx*BYTE_W +: BYTE_W] = byteData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      partial <= '0;
      wrPtr   <= '0;
      rdPtr   <= '0;
    end else if (strobe.clear) begin
      partial <= '0;
      wrPtr   <= '0;
      rdPtr   <= '0;
    end else begin
      if (strobe.take) partial <= asmRec;
      if (strobe.push) wrPtr <= bump(wrPtr);
      if (strobe.pop)  rdPtr <= bump(rdPtr);
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.push && !strobe.clear) slots[wrPtr] <= asmRec;
  end

  assign headRec = slots[rdPtr];
endmodule

// File: rtl/decq_top.sv
module decq_top
  import decq_pkg::*;
#(
  parameter int DEPTH = 3,
  parameter int LOW_WATER = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        flush,
  input  logic        byteValid,
  input  logic [7:0]  byteData,
  output logic        byteReq,
  output logic        outValid,
  input  logic        outReady,
  output logic [7:0]  outOpcode,
  output logic [23:0] outArgs,
  output logic [2:0]  outLen
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = $clog2(DEPTH);

  decq_strobe_t     strobe;
  decq_rec_t        headRec;
  logic [CNT_W-1:0] occ;
  logic [1:0]       byteIdx;

  decq_ctrl #(.DEPTH(DEPTH), .LOW_WATER(LOW_WATER), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .flush(flush), .byteValid(byteValid),
    .byteLenCode(byteData[1:0]), .outReady(outReady), .byteReq(byteReq),
    .outValid(outValid), .occ(occ), .byteIdx(byteIdx), .strobe(strobe)
  );

  decq_datapath #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .byteData(byteData),
    .headRec(headRec)
  );

  assign outOpcode = headRec.opcode;
  assign outArgs   = headRec.args;
  assign outLen    = {1'b0, headRec.lenCode} + 3'd1;
endmodule

// File: rtl/decq_checker.sv
module decq_checker #(
  parameter int DEPTH = 3,
  parameter int LOW_WATER = 1,
  parameter int CNT_W = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             flush,
  input logic             byteValid,
  input logic             byteReq,
  input logic             outValid,
  input logic             outReady,
  input logic [7:0]       outOpcode,
  input logic [23:0]      outArgs,
  input logic [2:0]       outLen,
  input logic [CNT_W-1:0] occ,
  input logic [1:0]       byteIdx
);
  assert_occ_limit_R4: assert property (@(posedge clk) disable iff (!rstN)
    occ <= CNT_W'(DEPTH));

  assert_full_no_req_R5: assert property (@(posedge clk) disable iff (!rstN)
    (occ == CNT_W'(DEPTH)) |-> !byteReq);

  assert_resume_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(byteReq) |-> (occ <= CNT_W'(LOW_WATER)));

  assert_stall_keep_R7: assert property (@(posedge clk) disable iff (!rstN)
    (byteReq && !byteValid && !flush) |=> $stable(byteIdx));

  assert_head_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !flush) |=>
      (outValid && $stable(outOpcode) && $stable(outArgs) && $stable(outLen)));

  assert_pad_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outLen == 3'd1) |-> (outArgs == 24'h0));

  assert_flush_empty_R9: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (!outValid && byteReq && occ == '0 && byteIdx == 2'd0));
endmodule

bind decq_top decq_checker #(.DEPTH(DEPTH), .LOW_WATER(LOW_WATER), .CNT_W(CNT_W)) chk (
  .clk(clk), .rstN(rstN), .flush(flush), .byteValid(byteValid),
  .byteReq(byteReq), .outValid(outValid), .outReady(outReady),
  .outOpcode(outOpcode), .outArgs(outArgs), .outLen(outLen),
  .occ(occ), .byteIdx(byteIdx)
);

// File: tb/tb_decq_top.sv
module tb_decq_top;
  logic        clk = 1'b0;
  logic        rstN, flush, byteValid, outReady;
  logic [7:0]  byteData;
  logic        byteReq, outValid;
  logic [7:0]  outOpcode;
  logic [23:0] outArgs;
  logic [2:0]  outLen;
  int          checks = 0;
  int          errors = 0;
  logic        done = 1'b0;

  always #5 clk = ~clk;

  decq_top dut (
    .clk(clk), .rstN(rstN), .flush(flush), .byteValid(byteValid),
    .byteData(byteData), .byteReq(byteReq), .outValid(outValid),
    .outReady(outReady), .outOpcode(outOpcode), .outArgs(outArgs),
    .outLen(outLen)
  );

  // {expected length, opcode byte, trailing bytes (first in [7:0])}
  localparam logic [34:0] VEC [6] = '{
    {3'd1, 8'h40, 24'hAABBCC},
    {3'd4, 8'h83, 24'h030201},
    {3'd2, 8'h11, 24'h9988F0},
    {3'd3, 8'h26, 24'h776655},
    {3'd4, 8'hFF, 24'h0A0B0C},
    {3'd1, 8'h04, 24'h123456}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic feed(input logic [7:0] b);
    @(negedge clk);
    byteValid = 1'b1;
    byteData  = b;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int fv, fb, ei;
    rstN = 1'b0; flush = 1'b0; byteValid = 1'b0; byteData = 8'h0; outReady = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset outValid", 32'(outValid), 32'd0);
    check("R1 reset byteReq", 32'(byteReq), 32'd1);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 post-reset outValid", 32'(outValid), 32'd0);
    check("R1 post-reset byteReq", 32'(byteReq), 32'd1);

    // table walk: R2, R3, R4 with a draining consumer
    outReady = 1'b1; fv = 0; fb = 0; ei = 0;
    for (int cyc = 0; cyc < 200 && ei < 6; cyc++) begin
      @(negedge clk);
      if (outValid) begin
        logic [2:0]  eLen;
        logic [23:0] eArgs;
        eLen  = VEC[ei][34:32];
        eArgs = VEC[ei][23:0] & 24'((32'd1 << (8 * (eLen - 3'd1))) - 32'd1);
        check("R2 opcode", 32'(outOpcode), 32'(VEC[ei][31:24]));
        check("R2 args", 32'(outArgs), 32'(eArgs));
        check("R2 length", 32'(outLen), 32'(eLen));
        ei++;
      end
      if (byteReq && fv < 6) begin
        byteValid = 1'b1;
        byteData  = (fb == 0) ? VEC[fv][31:24] : 8'(VEC[fv][23:0] >> (8 * (fb - 1)));
        fb++;
        if (fb == int'(VEC[fv][34:32])) begin fv++; fb = 0; end
      end else begin
        byteValid = 1'b0;
      end
    end
    check("R4 all table records in order", 32'(ei), 32'd6);
    @(negedge clk); byteValid = 1'b0; outReady = 1'b0;

    // low-water hysteresis: R3, R4, R5, R6
    feed(8'h40);
    feed(8'h44);
    check("R3 record one cycle after last byte", 32'(outValid), 32'd1);
    check("R6 request held at one record", 32'(byteReq), 32'd1);
    feed(8'h48);
    check("R6 request held at two records", 32'(byteReq), 32'd1);
    feed(8'hFF);
    check("R5 request drops when full", 32'(byteReq), 32'd0);
    repeat (3) @(negedge clk);
    byteValid = 1'b0;
    check("R5 still no request when full", 32'(byteReq), 32'd0);
    check("R4 head is first record", 32'(outOpcode), 32'h40);
    outReady = 1'b1;
    @(negedge clk);
    check("R5 no request at two records", 32'(byteReq), 32'd0);
    check("R4 second record", 32'(outOpcode), 32'h44);
    @(negedge clk);
    check("R5 request resumes at one record", 32'(byteReq), 32'd1);
    check("R4 third record", 32'(outOpcode), 32'h48);
    @(negedge clk);
    check("R4 queue empty after three pops", 32'(outValid), 32'd0);
    outReady = 1'b0;

    // stall keeps the partial record: R7, R8
    feed(8'h03);
    @(negedge clk); byteValid = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 no record while stalled", 32'(outValid), 32'd0);
    byteValid = 1'b1; byteData = 8'h11;
    @(negedge clk); byteData = 8'h22;
    @(negedge clk); byteValid = 1'b0;
    @(negedge clk);
    check("R7 still incomplete", 32'(outValid), 32'd0);
    byteValid = 1'b1; byteData = 8'h33;
    @(negedge clk); byteValid = 1'b0;
    check("R7 record completes", 32'(outValid), 32'd1);
    check("R7 opcode kept", 32'(outOpcode), 32'h03);
    check("R7 args assembled across stalls", 32'(outArgs), 32'h332211);
    check("R2 four byte length", 32'(outLen), 32'd4);
    repeat (3) @(negedge clk);
    check("R8 held while not ready", 32'(outValid), 32'd1);
    check("R8 args stable", 32'(outArgs), 32'h332211);
    outReady = 1'b1;
    @(negedge clk); outReady = 1'b0;
    check("R8 removed on handshake", 32'(outValid), 32'd0);

    // flush: R9
    feed(8'h40);
    feed(8'h44);
    feed(8'h02);
    feed(8'h55);
    @(negedge clk);
    flush = 1'b1; byteValid = 1'b1; byteData = 8'h40;
    @(negedge clk);
    flush = 1'b0; byteValid = 1'b0;
    check("R9 queue empty after flush", 32'(outValid), 32'd0);
    check("R9 request after flush", 32'(byteReq), 32'd1);
    byteValid = 1'b1; byteData = 8'h40;
    @(negedge clk); byteValid = 1'b0;
    check("R9 fresh record visible", 32'(outValid), 32'd1);
    check("R9 partial discarded opcode", 32'(outOpcode), 32'h40);
    check("R9 fresh length", 32'(outLen), 32'd1);
    check("R9 fresh args", 32'(outArgs), 32'd0);
    outReady = 1'b1;
    @(negedge clk); outReady = 1'b0;
    check("R9 byte during flush not taken", 32'(outValid), 32'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule